// File: doc/BRIEF.md
# Split-Word Interrupt Register File with Two-Line Routing

This block is the software-facing half of an interrupt controller for 51 sources. Each 51-bit control or status vector is reached through a 32-bit bus as two words. The lower word holds bits 31:0 and sits at an address with bit 2 clear. The upper word holds bits 50:32 in its low 19 bits and sits four bytes above. The map begins at byte offset 0x80. Nothing below 0x80 is decoded.

The block keeps the per-source routing choice (normal line or fast line) and the enable vector. Enable has separate set and clear addresses, so no read-modify-write is needed. The block also keeps the trigger configuration: level/edge sense, dual-edge and polarity. Sense and dual-edge are fixed. Only four bits of polarity can be changed. The configuration goes out to an external trigger detector. That detector returns the latched raw status vector and accepts a one-cycle edge-clear pulse from this block.

Two registered outputs report pending work. The fast line reports raw, enabled sources steered to it. The normal line reports raw, enabled sources not steered to it. Reads are registered and return data the cycle after the read strobe.

Top module: `splitword_intc`

## Requirements
- R1: After reset: select reads 0 and enable reads 0. Sense reads 0xFFF8FFFF low and 0x1F07 high. Dual-edge reads 0x00070000 low and 0xF8 high. Polarity (event) reads 0xFFF8FFFF low and 0x5F07 high. Both interrupt outputs are low.
- R2: An upper-word write uses only data bits 18:0, placed on source bits 50:32. Upper-word reads return zero in bits 31:19.
- R3: A write to the enable-set word (0xA0/0xA4) ORs the data into the addressed half of enable.
- R4: A write to the enable-clear word (0xA8/0xAC) clears every enable bit written as 1 in the addressed half and leaves all other enable bits unchanged.
- R5: A write to select (0x98/0x9C) replaces only the addressed half. The other half keeps its value.
- R6: Polarity (0xD0/0xD4) changes only in source bits 50:47, which are upper-word data bits 18:15. A lower-word polarity write has no effect.
- R7: The fast output is high one clock after any bit of raw AND enable AND select is set. The normal output is high one clock after any bit of raw AND enable AND NOT select is set. A change in raw or enable reaches the outputs one clock later.
- R8: The following reads return, for the addressed half:
  - normal status (0x80/0x84): raw AND enable AND NOT select
  - fast status (0x88/0x8C): raw AND enable AND select
  - raw status (0x90/0x94): raw
  - edge status (0xE0/0xE4): raw AND NOT sense
- R9: The following reads return 0:
  - enable-clear, software-interrupt (0xB0) and software-clear (0xB8)
  - edge-clear (0xD8)
  - unmapped offsets and offsets below 0x80
  
  Writes to read-only words (sense 0xC0, dual-edge 0xC8, status words) change nothing.
- R10: A write to the edge-clear word (0xD8/0xDC) drives edgeClr for exactly one cycle, the cycle after the write. The pulse carries the data, aligned to the addressed half and masked by NOT sense.
- R11: Read data is registered. It reflects the addressed word in the cycle after busRd is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | 8 | Byte address, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| rawStatus | input | 51 | Latched raw status from trigger detector |
| cfgSense | output | 51 | Level(1)/edge(0) sense configuration |
| cfgDualEdge | output | 51 | Dual-edge configuration |
| cfgEvent | output | 51 | Polarity configuration |
| edgeClr | output | 51 | One-cycle edge-clear pulse |
| irqOut | output | 1 | Normal interrupt line |
| fiqOut | output | 1 | Fast interrupt line |

## Verification
The two functions that can land in the same cycle are a bus write to the enable vector and a change on the raw status input. The bench raises a raw bit in the same cycle in which it clears that source's enable. Because the outputs are registered, the normal line must go high for one cycle, using the old enable, and then drop. The bench checks both the high cycle and the drop against the timing in R7.

// File: rtl/splitword_intc_pkg.sv
package splitword_intc_pkg;

  typedef enum logic [3:0] {
    RdNone, RdIrq, RdFiq, RdRaw, RdSel, RdEn, RdSense, RdDual, RdEvent, RdEdge
  } rdSrcE;

  typedef struct packed {
    logic  wrSel;
    logic  wrEnSet;
    logic  wrEnClr;
    logic  wrEvent;
    logic  wrEdgeClr;
    logic  hiHalf;
    logic  rdStb;
    rdSrcE rdSrc;
  } strobeT;

endpackage

// File: rtl/splitword_intc_ctrl.sv
module splitword_intc_ctrl
  import splitword_intc_pkg::*;
#(
  parameter int AddrW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [AddrW-1:0] busAddr,
  output strobeT           str
);

  localparam logic [AddrW-1:0] OffIrq     = AddrW'('h80);
  localparam logic [AddrW-1:0] OffFiq     = AddrW'('h88);
  localparam logic [AddrW-1:0] OffRaw     = AddrW'('h90);
  localparam logic [AddrW-1:0] OffSel     = AddrW'('h98);
  localparam logic [AddrW-1:0] OffEn      = AddrW'('hA0);
  localparam logic [AddrW-1:0] OffEnClr   = AddrW'('hA8);
  localparam logic [AddrW-1:0] OffSense   = AddrW'('hC0);
  localparam logic [AddrW-1:0] OffDual    = AddrW'('hC8);
  localparam logic [AddrW-1:0] OffEvent   = AddrW'('hD0);
  localparam logic [AddrW-1:0] OffEdgeClr = AddrW'('hD8);
  localparam logic [AddrW-1:0] OffEdgeSts = AddrW'('hE0);

  logic             aligned;
  logic [AddrW-1:0] baseAddr;

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign baseAddr = {busAddr[AddrW-1:3], 3'b000};

  always_comb begin
    str        = '0;
    str.rdSrc  = RdNone;
    str.hiHalf = busAddr[2];
    str.rdStb  = busRd;
    if (aligned) begin
      case (baseAddr)
        OffIrq:     str.rdSrc = RdIrq;
        OffFiq:     str.rdSrc = RdFiq;
        OffRaw:     str.rdSrc = RdRaw;
        OffSel: begin
          str.rdSrc = RdSel;
          str.wrSel = busWr;
        end
        OffEn: begin
          str.rdSrc   = RdEn;
          str.wrEnSet = busWr;
        end
        OffEnClr:   str.wrEnClr = busWr;
        OffSense:   str.rdSrc = RdSense;
        OffDual:    str.rdSrc = RdDual;
        OffEvent: begin
          str.rdSrc   = RdEvent;
          str.wrEvent = busWr & busAddr[2];
        end
        OffEdgeClr: str.wrEdgeClr = busWr;
        OffEdgeSts: str.rdSrc = RdEdge;
        default:    str.rdSrc = RdNone;
      endcase
    end
  end

  // R9: at most one register is written per bus cycle
  p_one_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({str.wrSel, str.wrEnSet, str.wrEnClr, str.wrEvent, str.wrEdgeClr}));

  // R6: a lower-word polarity access never produces a polarity write
  p_event_low_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (str.wrEvent |-> busAddr[2]));

endmodule

// File: rtl/splitword_intc_dp.sv
module splitword_intc_dp
  import splitword_intc_pkg::*;
#(
  parameter int              NumSrc    = 51,
  parameter logic [NumSrc-1:0] SenseInit = 51'h1F07FFF8FFFF,
  parameter logic [NumSrc-1:0] DualInit  = 51'h00F800070000,
  parameter logic [NumSrc-1:0] EventInit = 51'h5F07FFF8FFFF,
  parameter logic [NumSrc-1:0] EvtWrMask = 51'h7800000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobeT            str,
  input  logic [31:0]       busWdata,
  input  logic [NumSrc-1:0] rawStatus,
  output logic [31:0]       busRdata,
  output logic [NumSrc-1:0] cfgSense,
  output logic [NumSrc-1:0] cfgDualEdge,
  output logic [NumSrc-1:0] cfgEvent,
  output logic [NumSrc-1:0] edgeClr,
  output logic              irqOut,
  output logic              fiqOut
);

  localparam int LoW = 32;
  localparam int HiW = NumSrc - LoW;

  logic [NumSrc-1:0] selectQ, enableQ, eventQ;
  logic [NumSrc-1:0] wideData, halfMask, pending, fullRd;
  logic [31:0]       rdWord;

  assign wideData = str.hiHalf ? {busWdata[HiW-1:0], {LoW{1'b0}}}
                               : {{HiW{1'b0}}, busWdata};
  assign halfMask = str.hiHalf ? {{HiW{1'b1}}, {LoW{1'b0}}}
                               : {{HiW{1'b0}}, {LoW{1'b1}}};

  assign cfgSense    = SenseInit;
  assign cfgDualEdge = DualInit;
  assign cfgEvent    = eventQ;
  assign pending     = rawStatus & enableQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selectQ <= '0;
      enableQ <= '0;
      eventQ  <= EventInit;
      edgeClr <= '0;
      irqOut  <= 1'b0;
      fiqOut  <= 1'b0;
    end else begin
      if (str.wrSel)     selectQ <= (selectQ & ~halfMask) | wideData;
      if (str.wrEnSet)   enableQ <= enableQ | wideData;
      else if (str.wrEnClr) enableQ <= enableQ & ~wideData;
      if (str.wrEvent)   eventQ  <= (eventQ & ~EvtWrMask) | (wideData & EvtWrMask);
      edgeClr <= str.wrEdgeClr ? (wideData & ~SenseInit) : '0;
      irqOut  <= |(pending & ~selectQ);
      fiqOut  <= |(pending & selectQ);
    end
  end

  always_comb begin
    case (str.rdSrc)
      RdIrq:   fullRd = pending & ~selectQ;
      RdFiq:   fullRd = pending & selectQ;
      RdRaw:   fullRd = rawStatus;
      RdSel:   fullRd = selectQ;
      RdEn:    fullRd = enableQ;
      RdSense: fullRd = SenseInit;
      RdDual:  fullRd = DualInit;
      RdEvent: fullRd = eventQ;
      RdEdge:  fullRd = rawStatus & ~SenseInit;
      default: fullRd = '0;
    endcase
    rdWord = str.hiHalf ? {{(32-HiW){1'b0}}, fullRd[NumSrc-1:LoW]} : fullRd[LoW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         busRdata <= '0;
    else if (str.rdStb) busRdata <= rdWord;
  end

  p_enable_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    str.wrEnSet |=> (($past(wideData) & ~enableQ) == '0));

  p_enable_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    str.wrEnClr |=> ((enableQ & $past(wideData)) == '0));

  p_select_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (str.wrSel && !str.hiHalf) |=> (selectQ[NumSrc-1:LoW] == $past(selectQ[NumSrc-1:LoW])));

  p_event_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((eventQ & ~EvtWrMask) == (EventInit & ~EvtWrMask)));

  p_quiet_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |=> (!irqOut && !fiqOut));

  p_edge_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeClr != '0) |-> $past(str.wrEdgeClr));

endmodule

// File: rtl/splitword_intc.sv
module splitword_intc
  import splitword_intc_pkg::*;
#(
  parameter int                NumSrc    = 51,
  parameter int                AddrW     = 8,
  parameter logic [NumSrc-1:0] SenseInit = 51'h1F07FFF8FFFF,
  parameter logic [NumSrc-1:0] DualInit  = 51'h00F800070000,
  parameter logic [NumSrc-1:0] EventInit = 51'h5F07FFF8FFFF,
  parameter logic [NumSrc-1:0] EvtWrMask = 51'h7800000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [AddrW-1:0]  busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [NumSrc-1:0] rawStatus,
  output logic [NumSrc-1:0] cfgSense,
  output logic [NumSrc-1:0] cfgDualEdge,
  output logic [NumSrc-1:0] cfgEvent,
  output logic [NumSrc-1:0] edgeClr,
  output logic              irqOut,
  output logic              fiqOut
);

  strobeT str;

  splitword_intc_ctrl #(.AddrW(AddrW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .str     (str)
  );

  splitword_intc_dp #(
    .NumSrc    (NumSrc),
    .SenseInit (SenseInit),
    .DualInit  (DualInit),
    .EventInit (EventInit),
    .EvtWrMask (EvtWrMask)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .str         (str),
    .busWdata    (busWdata),
    .rawStatus   (rawStatus),
    .busRdata    (busRdata),
    .cfgSense    (cfgSense),
    .cfgDualEdge (cfgDualEdge),
    .cfgEvent    (cfgEvent),
    .edgeClr     (edgeClr),
    .irqOut      (irqOut),
    .fiqOut      (fiqOut)
  );

endmodule

// File: tb/sim_splitword_intc.sv
`timescale 1ns/1ps
module sim_splitword_intc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [50:0] rawStatus = '0;
  logic [50:0] cfgSense, cfgDualEdge, cfgEvent, edgeClr;
  logic        irqOut, fiqOut;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdPend = 1'b0;

  always #2.5 clk = ~clk;

  splitword_intc u0 (
    .clk(clk), .rst_n(rst_n), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rawStatus(rawStatus),
    .cfgSense(cfgSense), .cfgDualEdge(cfgDualEdge), .cfgEvent(cfgEvent),
    .edgeClr(edgeClr), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // monitor: capture of a read at the edge, compare after it (R11 timing)
  always @(posedge clk) rdPend <= busRd;
  always @(negedge clk) begin
    if (rdPend) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: actual 0x%0h expected no read", busRdata);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(t, {32'b0, busRdata}, {32'b0, e});
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", {63'b0, irqOut}, 64'd0);
    check("R1 fiq", {63'b0, fiqOut}, 64'd0);
    doRead(8'hC0, 32'hFFF8FFFF, "R1 sense lo");
    doRead(8'hC4, 32'h00001F07, "R1 sense hi");
    doRead(8'hC8, 32'h00070000, "R1 dual lo");
    doRead(8'hCC, 32'h000000F8, "R1 dual hi");
    doRead(8'hD0, 32'hFFF8FFFF, "R1 event lo");
    doRead(8'hD4, 32'h00005F07, "R1 event hi");
    doRead(8'h98, 32'h0, "R1 select lo");
    doRead(8'hA0, 32'h0, "R1 enable lo");

    doWrite(8'hA0, 32'h000000F0);
    doWrite(8'hA0, 32'h0000000F);
    doRead(8'hA0, 32'h000000FF, "R3 enable OR");
    doWrite(8'hA4, 32'hFFFFFFFF);
    doRead(8'hA4, 32'h0007FFFF, "R2 hi 19 bits");
    doWrite(8'hA8, 32'h0000003C);
    doRead(8'hA0, 32'h000000C3, "R4 enable clear lo");
    doWrite(8'hAC, 32'h0007FFF0);
    doRead(8'hA4, 32'h0000000F, "R4 enable clear hi");
    doRead(8'hA0, 32'h000000C3, "R4 other half kept");

    doWrite(8'h98, 32'h00000081);
    doWrite(8'h9C, 32'h00000005);
    doWrite(8'h98, 32'h00000002);
    doRead(8'h98, 32'h00000002, "R5 select lo");
    doRead(8'h9C, 32'h00000005, "R5 select hi kept");

    doWrite(8'hD0, 32'h00000000);
    doRead(8'hD0, 32'hFFF8FFFF, "R6 event lo ignored");
    doWrite(8'hD4, 32'hFFFFFFFF);
    doRead(8'hD4, 32'h0007DF07, "R6 event hi mask");
    doWrite(8'hD4, 32'h00000000);
    doRead(8'hD4, 32'h00005F07, "R6 event hi clear");

    doWrite(8'hC0, 32'h00000000);
    doRead(8'hC0, 32'hFFF8FFFF, "R9 sense read-only");
    doRead(8'hA8, 32'h0, "R9 enable-clear reads 0");
    doRead(8'hB0, 32'h0, "R9 sw trigger reads 0");
    doRead(8'hB8, 32'h0, "R9 sw clear reads 0");
    doRead(8'hD8, 32'h0, "R9 edge-clear reads 0");
    doRead(8'h40, 32'h0, "R9 below map reads 0");

    // routing: enable lo C3 hi F, select lo 2 hi 5
    @(negedge clk);
    rawStatus = 51'h1;
    @(negedge clk);
    check("R7 irq after one clock", {63'b0, irqOut}, 64'd1);
    check("R7 fiq stays low", {63'b0, fiqOut}, 64'd0);
    rawStatus = 51'h2;
    check("R7 irq registered", {63'b0, irqOut}, 64'd1);
    @(negedge clk);
    check("R7 fiq routed", {63'b0, fiqOut}, 64'd1);
    check("R7 irq dropped", {63'b0, irqOut}, 64'd0);
    rawStatus = 51'h4;
    @(negedge clk);
    check("R7 disabled source", {62'b0, irqOut, fiqOut}, 64'd0);

    rawStatus = {19'h2, 32'h00010003};
    doRead(8'h80, 32'h00000001, "R8 irq status lo");
    doRead(8'h84, 32'h00000002, "R8 irq status hi");
    doRead(8'h88, 32'h00000002, "R8 fiq status lo");
    doRead(8'h8C, 32'h00000000, "R8 fiq status hi");
    doRead(8'h90, 32'h00010003, "R11 raw lo");
    doRead(8'hE0, 32'h00010000, "R8 edge status lo");
    doRead(8'hE4, 32'h00000000, "R8 edge status hi");

    // concurrent: raw rises in the cycle its enable is cleared
    rawStatus = '0;
    repeat (2) @(negedge clk);
    check("R7 idle", {63'b0, irqOut}, 64'd0);
    rawStatus = 51'h1;
    busWr = 1'b1; busAddr = 8'hA8; busWdata = 32'h1;
    @(negedge clk);
    busWr = 1'b0;
    check("R7 old enable seen", {63'b0, irqOut}, 64'd1);
    @(negedge clk);
    check("R7 cleared enable seen", {63'b0, irqOut}, 64'd0);
    rawStatus = '0;

    doWrite(8'hD8, 32'hFFFFFFFF);
    check("R10 edge pulse lo", {13'b0, edgeClr}, 64'h0000000000070000);
    @(negedge clk);
    check("R10 pulse one cycle", {13'b0, edgeClr}, 64'h0);
    doWrite(8'hDC, 32'hFFFFFFFF);
    check("R10 edge pulse hi", {13'b0, edgeClr}, 64'h0007E0F800000000);
    @(negedge clk);
    check("R10 pulse hi one cycle", {13'b0, edgeClr}, 64'h0);

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11: actual %0d pending reads expected 0", expQ.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule